// File: doc/BRIEF.md
# Cartridge Bank Mapper with Pattern RAM Substitution

This block is the address-translation logic of a game cartridge for an 8-bit console. The processor writes to the upper half of its address space, and those writes load a set of bank registers: two switchable program windows, a nametable mirroring selector, and eight pattern bank registers, one for each 1 KB slot of the video pattern space. Processor reads in the upper half are turned into an address in an 8 KB-banked program ROM. Video-side pattern accesses are turned into an address in a 1 KB-banked pattern ROM.

Two raw pattern bank numbers (4 and 5 by default) do not reach the ROM. An access through a slot holding one of them goes to a 2 KB RAM inside the block, which the video side can both read and write. Writes through any other bank are dropped. The ROMs themselves sit outside the block. The interrupt output exists for board compatibility and is held low, because the interrupt counter lies outside this block.

Top module: `cart_mapper`

## Requirements
- R1: A processor write to $8000-$8FFF loads the first program bank register with the data, masked to log2(PRG_ROM_BANKS) bits. A read in $8000-$9FFF gives prg_addr = bank*8192 + cpu_addr[12:0].
- R2: A write to $A000-$AFFF loads the second program bank register, which maps $A000-$BFFF. The window at $C000-$DFFF is fixed to bank PRG_ROM_BANKS-2.
- R3: The window at $E000-$FFFF is always fixed to bank PRG_ROM_BANKS-1, including straight after reset.
- R4: After reset, mirror is 0 (vertical). A write to $9000-$9FFF loads mirror with data[1:0], where 0 is vertical, 1 horizontal, 2 single-screen low and 3 single-screen high.
- R5: Writes in $B000-$EFFF load pattern slot 2*(cpu_addr[15:12]-4'hB)+cpu_addr[3]. When cpu_addr[2] is 0 the write loads bits 3:0 of the slot register from data[3:0]; when it is 1 it loads bits 7:4. Every slot register resets to 0.
- R6: The video slot is vid_addr[12:10]. For a slot whose raw bank b is not a RAM bank, chr_rom_addr = b*1024 + vid_addr[9:0] and vid_rdata equals chr_rom_data, with no clock delay.
- R7: For a raw bank b equal to 4 or 5, vid_rdata comes combinationally from internal RAM location (b-4)*1024 + vid_addr[9:0].
- R8: A video write with vid_we high is stored on the clock edge only when the addressed slot holds bank 4 or 5. A write through any other bank changes neither the RAM nor what later reads return.
- R9: Banks 4 and 5 are separate storage. Two slots that hold the same RAM bank see the same bytes.
- R10: irq stays at 0 at all times.
- R11: Processor writes below $8000 and in $F000-$FFFF change no register.

Port list and widths:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | Processor write strobe |
| cpu_addr | input | 16 | Processor address, used for both register writes and program reads |
| cpu_data | input | 8 | Processor write data |
| prg_addr | output | 17 | Program ROM byte address (default of 16 banks) |
| vid_addr | input | 13 | Video pattern address |
| vid_we | input | 1 | Video write strobe |
| vid_wdata | input | 8 | Video write data |
| vid_rdata | output | 8 | Video read data, taken from ROM or internal RAM |
| chr_rom_addr | output | 18 | Pattern ROM byte address |
| chr_rom_data | input | 8 | Pattern ROM data returned for chr_rom_addr |
| mirror | output | 2 | Nametable mirroring mode |
| irq | output | 1 | Interrupt request, held low |

## Verification
The bench targets the edges of the RAM decision. Bank 3 must still read ROM after bank 4 has been written. A design with a loose range compare would send bank 3 or bank 6 into RAM and return the RAM byte in place of the ROM pattern. A write through bank 3 at offset 0 is followed by a read of RAM bank 4 at offset 0, so a design that ignores the routing on writes corrupts the RAM. The bench writes different bytes through banks 4 and 5 at the same offset, which catches a RAM index that drops the bank bit. It also loads a bank value by its two nibble halves, which exposes swapped nibbles or a slot decode that misuses address bit 3.

// File: rtl/cart_mapper_pkg.sv
package cart_mapper_pkg;

    localparam int CHR_SLOTS   = 8;
    localparam int SLOT_W      = 3;
    localparam int CHR_BANK_W  = 8;
    localparam int KB_OFS_W    = 10;
    localparam int PRG_OFS_W   = 13;

    typedef enum logic [1:0] {
        MIR_VERT    = 2'd0,
        MIR_HORIZ   = 2'd1,
        MIR_SCR_LO  = 2'd2,
        MIR_SCR_HI  = 2'd3
    } mirror_e;

    typedef struct packed {
        logic              prg0;
        logic              prg1;
        logic              mir;
        logic              chr;
        logic [SLOT_W-1:0] slot;
        logic              hi;
    } cpu_dec_t;

    function automatic cpu_dec_t decode_cpu(input logic [15:0] a);
        cpu_dec_t d;
        logic [3:0] rel;
        d      = '0;
        rel    = a[15:12] - 4'hB;
        d.slot = {rel[1:0], a[3]};
        d.hi   = a[2];
        unique case (a[15:12])
            4'h8:                      d.prg0 = 1'b1;
            4'h9:                      d.mir  = 1'b1;
            4'hA:                      d.prg1 = 1'b1;
            4'hB, 4'hC, 4'hD, 4'hE:    d.chr  = 1'b1;
            default: ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/mapper_regs.sv
module mapper_regs
    import cart_mapper_pkg::*;
#(
    parameter int PRG_W = 4
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  cpu_we,
    input  logic [15:0]                           cpu_addr,
    input  logic [7:0]                            cpu_data,
    output logic [PRG_W-1:0]                      prg_bank0,
    output logic [PRG_W-1:0]                      prg_bank1,
    output mirror_e                               mirror_mode,
    output logic [CHR_SLOTS-1:0][CHR_BANK_W-1:0]  chr_banks
);

    cpu_dec_t dec;
    assign dec = decode_cpu(cpu_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            prg_bank0   <= '0;
            prg_bank1   <= '0;
            mirror_mode <= MIR_VERT;
            chr_banks   <= '0;
        end else if (cpu_we) begin
            if (dec.prg0) prg_bank0 <= cpu_data[PRG_W-1:0];
            if (dec.prg1) prg_bank1 <= cpu_data[PRG_W-1:0];
            if (dec.mir)  mirror_mode <= mirror_e'(cpu_data[1:0]);
            if (dec.chr) begin
                if (dec.hi) chr_banks[dec.slot][7:4] <= cpu_data[3:0];
                else        chr_banks[dec.slot][3:0] <= cpu_data[3:0];
            end
        end
    end

    // R1: the first program window register follows a write to $8xxx
    p_prg_load_r1: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && cpu_addr[15:12] == 4'h8) |=> prg_bank0 == $past(cpu_data[PRG_W-1:0]));

    // R4: the mirroring register follows a write to $9xxx
    p_mirror_load_r4: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && cpu_addr[15:12] == 4'h9) |=> mirror_mode == mirror_e'($past(cpu_data[1:0])));

    // R5: a low-nibble write to $B000 reaches slot 0 and leaves its upper half alone
    p_chr_low_nibble_r5: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && cpu_addr[15:12] == 4'hB && cpu_addr[3:2] == 2'b00)
        |=> (chr_banks[0][3:0] == $past(cpu_data[3:0]) && $stable(chr_banks[0][7:4])));

endmodule

// File: rtl/chr_route.sv
module chr_route
    import cart_mapper_pkg::*;
#(
    parameter int RAM_FIRST_BANK = 4,
    parameter int RAM_BANK_COUNT = 2,
    localparam int RSEL_W = $clog2(RAM_BANK_COUNT),
    localparam int RAM_AW = RSEL_W + KB_OFS_W
) (
    input  logic [CHR_SLOTS-1:0][CHR_BANK_W-1:0]  chr_banks,
    input  logic [12:0]                           vid_addr,
    output logic                                  is_ram,
    output logic [RAM_AW-1:0]                     ram_idx,
    output logic [CHR_BANK_W+KB_OFS_W-1:0]        rom_addr
);

    logic [SLOT_W-1:0]     slot;
    logic [CHR_BANK_W-1:0] raw;
    logic [CHR_BANK_W-1:0] rel;

    always_comb begin
        slot     = vid_addr[12:10];
        raw      = chr_banks[slot];
        rel      = raw - CHR_BANK_W'(RAM_FIRST_BANK);
        is_ram   = (raw >= CHR_BANK_W'(RAM_FIRST_BANK)) &&
                   (rel < CHR_BANK_W'(RAM_BANK_COUNT));
        ram_idx  = {rel[RSEL_W-1:0], vid_addr[KB_OFS_W-1:0]};
        rom_addr = {raw, vid_addr[KB_OFS_W-1:0]};
    end

endmodule

// File: rtl/chr_ram.sv
module chr_ram #(
    parameter int AW = 11,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/cart_mapper.sv
module cart_mapper
    import cart_mapper_pkg::*;
#(
    parameter int PRG_ROM_BANKS  = 16,
    parameter int RAM_FIRST_BANK = 4,
    parameter int RAM_BANK_COUNT = 2,
    localparam int PRG_W    = $clog2(PRG_ROM_BANKS),
    localparam int PRG_AW   = PRG_W + PRG_OFS_W,
    localparam int CHR_AW   = CHR_BANK_W + KB_OFS_W,
    localparam int RAM_AW   = $clog2(RAM_BANK_COUNT) + KB_OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_we,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_data,
    output logic [PRG_AW-1:0] prg_addr,
    input  logic [12:0]       vid_addr,
    input  logic              vid_we,
    input  logic [7:0]        vid_wdata,
    output logic [7:0]        vid_rdata,
    output logic [CHR_AW-1:0] chr_rom_addr,
    input  logic [7:0]        chr_rom_data,
    output logic [1:0]        mirror,
    output logic              irq
);

    localparam logic [PRG_W-1:0] LAST_BANK   = PRG_W'(PRG_ROM_BANKS - 1);
    localparam logic [PRG_W-1:0] SECOND_LAST = PRG_W'(PRG_ROM_BANKS - 2);

    logic [PRG_W-1:0]                      prg_bank0, prg_bank1;
    mirror_e                               mirror_mode;
    logic [CHR_SLOTS-1:0][CHR_BANK_W-1:0]  chr_banks;
    logic                                  ram_sel;
    logic [RAM_AW-1:0]                     ram_idx;
    logic [7:0]                            ram_q;
    logic [PRG_W-1:0]                      win_bank;

    mapper_regs #(.PRG_W(PRG_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .cpu_we      (cpu_we),
        .cpu_addr    (cpu_addr),
        .cpu_data    (cpu_data),
        .prg_bank0   (prg_bank0),
        .prg_bank1   (prg_bank1),
        .mirror_mode (mirror_mode),
        .chr_banks   (chr_banks)
    );

    chr_route #(
        .RAM_FIRST_BANK (RAM_FIRST_BANK),
        .RAM_BANK_COUNT (RAM_BANK_COUNT)
    ) u_route (
        .chr_banks (chr_banks),
        .vid_addr  (vid_addr),
        .is_ram    (ram_sel),
        .ram_idx   (ram_idx),
        .rom_addr  (chr_rom_addr)
    );

    chr_ram #(.AW(RAM_AW)) u_ram (
        .clk   (clk),
        .we    (vid_we && ram_sel),
        .addr  (ram_idx),
        .wdata (vid_wdata),
        .rdata (ram_q)
    );

    always_comb begin
        unique case (cpu_addr[14:13])
            2'd0:    win_bank = prg_bank0;
            2'd1:    win_bank = prg_bank1;
            2'd2:    win_bank = SECOND_LAST;
            default: win_bank = LAST_BANK;
        endcase
    end

    assign prg_addr  = {win_bank, cpu_addr[PRG_OFS_W-1:0]};
    assign vid_rdata = ram_sel ? ram_q : chr_rom_data;
    assign mirror    = mirror_mode;
    assign irq       = 1'b0;

    // R6: a slot routed to ROM passes the ROM byte straight through
    p_rom_pass_r6: assert property (@(posedge clk) disable iff (rst)
        !ram_sel |-> vid_rdata == chr_rom_data);

    // R3: the top window always lands in the last program bank
    p_fixed_last_r3: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[15:13] == 3'b111) |-> prg_addr[PRG_AW-1:PRG_OFS_W] == LAST_BANK);

    // R8: a write through a ROM slot leaves the RAM byte under that index unchanged
    p_rom_write_dropped_r8: assert property (@(posedge clk) disable iff (rst)
        (vid_we && !ram_sel) |=> u_ram.mem[$past(ram_idx)] == $past(u_ram.mem[ram_idx]));

endmodule

// File: tb/cart_mapper_test.sv
module cart_mapper_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        cpu_we;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_data;
    logic [16:0] prg_addr;
    logic [12:0] vid_addr;
    logic        vid_we;
    logic [7:0]  vid_wdata;
    logic [7:0]  vid_rdata;
    logic [17:0] chr_rom_addr;
    logic [7:0]  chr_rom_data;
    logic [1:0]  mirror;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] rom_byte(input logic [7:0] bank, input logic [9:0] ofs);
        return bank ^ ofs[7:0] ^ 8'h5A;
    endfunction

    assign chr_rom_data = rom_byte(chr_rom_addr[17:10], chr_rom_addr[9:0]);

    cart_mapper uut (
        .clk          (clk),
        .rst          (rst),
        .cpu_we       (cpu_we),
        .cpu_addr     (cpu_addr),
        .cpu_data     (cpu_data),
        .prg_addr     (prg_addr),
        .vid_addr     (vid_addr),
        .vid_we       (vid_we),
        .vid_wdata    (vid_wdata),
        .vid_rdata    (vid_rdata),
        .chr_rom_addr (chr_rom_addr),
        .chr_rom_data (chr_rom_data),
        .mirror       (mirror),
        .irq          (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cpu_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = a; cpu_data = d;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic vid_wr(input logic [12:0] a, input logic [7:0] d);
        @(negedge clk);
        vid_we = 1'b1; vid_addr = a; vid_wdata = d;
        @(negedge clk);
        vid_we = 1'b0;
    endtask

    task automatic prg_rd(input logic [15:0] a, output logic [16:0] p);
        cpu_addr = a; #1; p = prg_addr;
    endtask

    task automatic vid_rd(input logic [12:0] a, output logic [7:0] d);
        vid_addr = a; #1; d = vid_rdata;
    endtask

    task automatic t_reset;
        logic [16:0] p;
        logic [7:0]  d;
        prg_rd(16'hE123, p);
        chk("R3 last bank after reset", {15'd0, p}, 32'h1E123);
        chk("R4 mirror after reset", {30'd0, mirror}, 32'd0);
        chk("R10 irq after reset", {31'd0, irq}, 32'd0);
        vid_rd(13'h0005, d);
        chk("R5 slot reset to bank 0", {24'd0, d}, {24'd0, rom_byte(8'd0, 10'h005)});
    endtask

    task automatic t_prg;
        logic [16:0] p;
        cpu_wr(16'h8000, 8'h23);
        prg_rd(16'h8010, p);
        chk("R1 first window masked bank", {15'd0, p}, 32'h06010);
        cpu_wr(16'hA7FF, 8'h09);
        prg_rd(16'hB456, p);
        chk("R2 second window", {15'd0, p}, 32'h13456);
        prg_rd(16'hC001, p);
        chk("R2 fixed second-last window", {15'd0, p}, 32'h1C001);
        prg_rd(16'hFFFF, p);
        chk("R3 last window top byte", {15'd0, p}, 32'h1FFFF);
    endtask

    task automatic t_mirror;
        cpu_wr(16'h9000, 8'h01);
        chk("R4 horizontal", {30'd0, mirror}, 32'd1);
        cpu_wr(16'h9000, 8'hFE);
        chk("R4 single screen low", {30'd0, mirror}, 32'd2);
        cpu_wr(16'h9000, 8'h00);
        chk("R4 back to vertical", {30'd0, mirror}, 32'd0);
    endtask

    task automatic t_chr_rom;
        logic [7:0] d;
        cpu_wr(16'hB000, 8'h03);
        vid_rd(13'h0005, d);
        chk("R6 rom addr bank 3", {14'd0, chr_rom_addr}, 32'(3*1024 + 5));
        chk("R6 rom data bank 3", {24'd0, d}, {24'd0, rom_byte(8'd3, 10'h005)});
        cpu_wr(16'hD00C, 8'h07);
        cpu_wr(16'hD008, 8'h02);
        vid_rd(13'h17AB, d);
        chk("R5 nibble assembly slot 5", {14'd0, chr_rom_addr}, 32'(8'h72 * 1024 + 10'h3AB));
        cpu_wr(16'hE008, 8'h06);
        vid_rd(13'h1C10, d);
        chk("R7 bank 6 stays in rom", {24'd0, d}, {24'd0, rom_byte(8'd6, 10'h010)});
    endtask

    task automatic t_ram;
        logic [7:0] d;
        cpu_wr(16'hB000, 8'h04);
        cpu_wr(16'hB008, 8'h05);
        vid_wr(13'h0000, 8'h11);
        vid_wr(13'h0400, 8'h22);
        vid_rd(13'h0000, d);
        chk("R7 ram bank 4 readback", {24'd0, d}, 32'h11);
        vid_rd(13'h0400, d);
        chk("R9 ram bank 5 separate", {24'd0, d}, 32'h22);
        cpu_wr(16'hC000, 8'h04);
        vid_rd(13'h0800, d);
        chk("R9 slot 2 aliases bank 4", {24'd0, d}, 32'h11);
        vid_wr(13'h0BFF, 8'hC3);
        vid_rd(13'h03FF, d);
        chk("R8 write via slot 2 seen in slot 0", {24'd0, d}, 32'hC3);
    endtask

    task automatic t_rom_write;
        logic [7:0] d;
        cpu_wr(16'hB000, 8'h03);
        vid_wr(13'h0000, 8'hFF);
        vid_rd(13'h0000, d);
        chk("R8 rom bank write ignored", {24'd0, d}, {24'd0, rom_byte(8'd3, 10'h000)});
        cpu_wr(16'hB000, 8'h04);
        vid_rd(13'h0000, d);
        chk("R8 ram untouched by rom write", {24'd0, d}, 32'h11);
    endtask

    task automatic t_ignored;
        logic [16:0] p;
        cpu_wr(16'h7000, 8'h01);
        cpu_wr(16'hF000, 8'h0F);
        cpu_wr(16'hF008, 8'h0F);
        chk("R11 mirror unchanged", {30'd0, mirror}, 32'd0);
        prg_rd(16'h8000, p);
        chk("R11 first window unchanged", {15'd0, p}, 32'h06000);
        chk("R10 irq stays low", {31'd0, irq}, 32'd0);
    endtask

    initial begin
        rst = 1'b1; cpu_we = 1'b0; cpu_addr = '0; cpu_data = '0;
        vid_we = 1'b0; vid_addr = '0; vid_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_prg;
        t_mirror;
        t_chr_rom;
        t_ram;
        t_rom_write;
        t_ignored;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule